// File: doc/BRIEF.md
# PDM Microphone Bit Clock and Edge Capture

This block drives the bit clock of up to eight digital microphones (four by default) and picks up their one-bit density-modulated data. The bit clock is made inside the system clock domain. The system clock `clk` counts as twice the reference rate: one reference period lasts two `clk` cycles. The bit clock therefore runs at the reference rate divided by (divide setting + 1), and each of its half periods lasts (divide setting + 1) cycles of `clk`. A setting of zero passes the reference rate through undivided. Every bit-clock transition is made by a register, so both edges are known in advance as single-cycle events in `clk`, and the capture logic uses those events directly.

Each channel takes one bit per bit-clock period, on the edge it selects: rising or falling. The channels are grouped in pairs. When a pair is put in shared-line mode, both of its channels take their data from the even channel's data line. The odd channel then samples on the edge opposite to the even one, which separates two microphones that drive one wire on alternate half periods. A channel-count setting turns channels off from the top index downward. The bit-clock output can be switched off by itself, and that also stops all capture. Each captured bit comes with a one-cycle strobe, and both are registered in `clk`.

Top module: `pdmcap_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `pdm_clk_o`, `bit_o` and `bit_vld_o` are all zero.
- R2: With `clk_out_en_i` high and `presc_i` = P held steady, `pdm_clk_o` holds each level for exactly P+1 `clk` cycles. After the enable is raised (with the clock previously held off), the first rising edge comes P+1 cycles later.
- R3: While `clk_out_en_i` is low, `pdm_clk_o` is low from the next cycle on and no `bit_vld_o` bit is asserted.
- R4: A channel whose effective edge select is 0 (rising) asserts its strobe in exactly the cycles in which `pdm_clk_o` has just gone from 0 to 1. In those cycles its `bit_o` bit equals its data line's value at that clock edge.
- R5: A channel whose effective edge select is 1 (falling) asserts its strobe in exactly the cycles in which `pdm_clk_o` has just gone from 1 to 0, with `bit_o` as in R4.
- R6: Each active channel gives exactly one strobe per bit-clock period: over any window its strobe count equals the number of its selected edges on `pdm_clk_o`.
- R7: Channel c is active only when c <= `num_ch_i`, so `num_ch_i` holds the channel count minus one. An inactive channel never strobes, and its `bit_o` bit keeps its last value.
- R8: When `stereo_i[p]` is 1, channels 2p and 2p+1 both read `pdm_dat_i[2p]`. Channel 2p+1 samples on the edge opposite to `edge_sel_i[2p]`; its own `edge_sel_i` bit and `pdm_dat_i[2p+1]` have no effect, and the two channels of the pair never strobe in the same cycle.
- R9: When `stereo_i[p]` is 0, channel c reads `pdm_dat_i[c]` and uses `edge_sel_i[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out_en_i | input | 1 | Enables the bit clock and capture |
| presc_i | input | PRESC_W | Divide setting P; half period is P+1 cycles |
| num_ch_i | input | $clog2(NCH) | Number of active channels minus one |
| stereo_i | input | NCH/2 | Per-pair shared-line mode |
| edge_sel_i | input | NCH | Per-channel capture edge, 0 rising, 1 falling |
| pdm_dat_i | input | NCH | Microphone data lines |
| pdm_clk_o | output | 1 | Microphone bit clock |
| bit_o | output | NCH | Last captured bit per channel |
| bit_vld_o | output | NCH | One-cycle strobe per captured bit |

## Verification
The bit-clock edge, the strobe and the captured bit all change on the same `clk` edge. A level change on `pdm_clk_o` therefore shows up in the same cycle as the strobe of every channel that samples on that edge, and the bit shown is the data that was present just before that edge. The bench drives data and reads outputs only on falling `clk` edges. It compares the clock level it sees now with the level it saw one cycle earlier, and it predicts each strobe from that edge and the channel's mapping. The bit it expects is the one it drove during the preceding half cycle. It measures clock timing by counting falling `clk` edges from the enable, expecting P+1 to each transition.

// File: rtl/pdmcap_pkg.sv
package pdmcap_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } pdmcap_edge_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } pdmcap_tick_t;

endpackage

// File: rtl/pdmcap_divider.sv
module pdmcap_divider
   import pdmcap_pkg::*;
#(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               bclk_o,
   output pdmcap_tick_t       tick_o
);

   initial begin
      if (PRESC_W < 1) $error("pdmcap_divider: PRESC_W must be at least 1");
   end

   logic [PRESC_W-1:0] half_cnt;
   logic               bclk_q;
   logic               at_end;

   assign at_end = en_i && (half_cnt >= presc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         bclk_q   <= 1'b0;
      end else if (!en_i) begin
         half_cnt <= '0;
         bclk_q   <= 1'b0;
      end else if (at_end) begin
         half_cnt <= '0;
         bclk_q   <= ~bclk_q;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end

   assign bclk_o      = bclk_q;
   assign tick_o.rise = at_end && !bclk_q;
   assign tick_o.fall = at_end &&  bclk_q;

   // R2: no transition before the half period has run out
   a_r2_half_period : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && ($past(half_cnt) < $past(presc_i))) |-> $stable(bclk_q));

   // R3: a disabled clock is low on the next cycle
   a_r3_clock_off : assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !bclk_q);

endmodule

// File: rtl/pdmcap_lane.sv
module pdmcap_lane
   import pdmcap_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  pdmcap_tick_t tick_i,
   input  logic         active_i,
   input  logic         edge_i,
   input  logic         din_i,
   output logic         bit_o,
   output logic         vld_o
);

   logic take;

   always_comb begin
      if (edge_i == EDGE_FALL) take = tick_i.fall;
      else                     take = tick_i.rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_o <= 1'b0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= active_i && take;
         if (active_i && take) bit_o <= din_i;
      end
   end

   // R7: a strobe only follows a cycle in which the lane was active
   a_r7_lane_active : assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $past(active_i));

endmodule

// File: rtl/pdmcap_top.sv
module pdmcap_top
   import pdmcap_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int PRESC_W = 8,
   localparam int NPAIR  = NCH / 2,
   localparam int CNT_W  = (NCH > 2) ? $clog2(NCH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_out_en_i,
   input  logic [PRESC_W-1:0] presc_i,
   input  logic [CNT_W-1:0]   num_ch_i,
   input  logic [NPAIR-1:0]   stereo_i,
   input  logic [NCH-1:0]     edge_sel_i,
   input  logic [NCH-1:0]     pdm_dat_i,
   output logic               pdm_clk_o,
   output logic [NCH-1:0]     bit_o,
   output logic [NCH-1:0]     bit_vld_o
);

   initial begin
      if (NCH < 2 || NCH > 8 || (NCH % 2) != 0)
         $error("pdmcap_top: NCH must be even and within 2..8");
   end

   pdmcap_tick_t      tick;
   logic [NCH-1:0]    eff_edge;
   logic [NCH-1:0]    eff_dat;
   logic [NCH-1:0]    active;

   pdmcap_divider #(.PRESC_W(PRESC_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (clk_out_en_i),
      .presc_i (presc_i),
      .bclk_o  (pdm_clk_o),
      .tick_o  (tick)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign eff_edge[2*p] = edge_sel_i[2*p];
      assign eff_dat[2*p]  = pdm_dat_i[2*p];
      assign eff_edge[2*p+1] = stereo_i[p] ? ~edge_sel_i[2*p] : edge_sel_i[2*p+1];
      assign eff_dat[2*p+1]  = stereo_i[p] ?  pdm_dat_i[2*p]  : pdm_dat_i[2*p+1];

      // R8: a shared-line pair alternates and never strobes together
      a_r8_pair_split : assert property (@(posedge clk) disable iff (!rst_n)
         $past(stereo_i[p]) |-> !(bit_vld_o[2*p] && bit_vld_o[2*p+1]));
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign active[c] = (CNT_W'(c) <= num_ch_i);

      pdmcap_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick),
         .active_i (active[c]),
         .edge_i   (eff_edge[c]),
         .din_i    (eff_dat[c]),
         .bit_o    (bit_o[c]),
         .vld_o    (bit_vld_o[c])
      );

      // R4: rising-edge channels strobe alongside a rising bit clock
      a_r4_rise_align : assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld_o[c] && !$past(eff_edge[c])) |-> $rose(pdm_clk_o));

      // R5: falling-edge channels strobe alongside a falling bit clock
      a_r5_fall_align : assert property (@(posedge clk) disable iff (!rst_n)
         (bit_vld_o[c] && $past(eff_edge[c])) |-> $fell(pdm_clk_o));
   end

endmodule

// File: tb/tb_pdmcap_top.sv
module tb_pdmcap_top;

   localparam int NCH = 4;
   localparam int PW  = 8;
   localparam int CW  = 2;
   localparam int NP  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [PW-1:0] presc = '0;
   logic [CW-1:0] num = '0;
   logic [NP-1:0] ster = '0;
   logic [NCH-1:0] esel = '0;
   logic [NCH-1:0] dat = '0;
   logic          pdm_clk;
   logic [NCH-1:0] bits;
   logic [NCH-1:0] vld;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   pdmcap_top #(.NCH(NCH), .PRESC_W(PW)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_out_en_i (en),
      .presc_i      (presc),
      .num_ch_i     (num),
      .stereo_i     (ster),
      .edge_sel_i   (esel),
      .pdm_dat_i    (dat),
      .pdm_clk_o    (pdm_clk),
      .bit_o        (bits),
      .bit_vld_o    (vld)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // Per-cycle prediction of strobes and bits over n cycles
   task automatic observe(input int n);
      logic last_clk;
      logic [NCH-1:0] hold;
      int strobes [NCH];
      int n_rise = 0;
      int n_fall = 0;
      last_clk = pdm_clk;
      hold = bits;
      for (int c = 0; c < NCH; c++) strobes[c] = 0;
      for (int i = 0; i < n; i++) begin
         logic now, r, f;
         @(negedge clk);
         now = pdm_clk;
         r = !last_clk && now;
         f = last_clk && !now;
         if (r) n_rise++;
         if (f) n_fall++;
         for (int c = 0; c < NCH; c++) begin
            bit act, shared, pol, ev;
            int line;
            act    = en && (c <= int'(num));
            shared = (c % 2 == 1) && ster[c/2];
            line   = shared ? c - 1 : c;
            pol    = shared ? ~esel[c-1] : esel[c];
            ev     = act && (pol ? f : r);
            if (!act)    check(vld[c] == 1'b0, "R7 strobe on inactive channel", vld[c], 0);
            else if (pol) check(vld[c] == ev, "R5 falling-edge strobe", vld[c], ev);
            else          check(vld[c] == ev, "R4 rising-edge strobe", vld[c], ev);
            if (ev) begin
               if (shared) check(bits[c] == dat[line], "R8 shared-line bit", bits[c], dat[line]);
               else        check(bits[c] == dat[line], "R9 own-line bit", bits[c], dat[line]);
            end
            if (vld[c]) strobes[c]++;
         end
         last_clk = now;
         dat = NCH'($urandom);
      end
      for (int c = 0; c < NCH; c++) begin
         bit shared, pol;
         shared = (c % 2 == 1) && ster[c/2];
         pol    = shared ? ~esel[c-1] : esel[c];
         if (en && c <= int'(num))
            check(strobes[c] == (pol ? n_fall : n_rise), "R6 one strobe per period",
                  strobes[c], pol ? n_fall : n_rise);
         else
            check(bits[c] == hold[c], "R7 inactive bit holds", bits[c], hold[c]);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(pdm_clk == 1'b0, "R1 clock in reset", pdm_clk, 0);
      check(vld == '0, "R1 strobes in reset", vld, 0);
      check(bits == '0, "R1 bits in reset", bits, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pdm_clk == 1'b0 && vld == '0 && bits == '0, "R1 first cycle after reset",
            {pdm_clk, vld, bits}, 0);
   endtask

   task automatic t_period(input int p);
      int k;
      en = 1'b0;
      repeat (2) @(negedge clk);
      presc = PW'(p);
      en = 1'b1;
      for (int edge_n = 0; edge_n < 3; edge_n++) begin
         logic start;
         start = pdm_clk;
         k = 0;
         while (pdm_clk == start && k < 300) begin
            @(negedge clk);
            k++;
         end
         check(k == p + 1, "R2 half period length", k, p + 1);
      end
   endtask

   task automatic t_disable();
      en = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         check(pdm_clk == 1'b0, "R3 clock low while off", pdm_clk, 0);
         check(vld == '0, "R3 no strobes while off", vld, 0);
         dat = NCH'($urandom);
         @(negedge clk);
      end
   endtask

   task automatic t_mono();
      en = 1'b0; @(negedge clk);
      presc = 8'd2; num = 2'd3; ster = 2'b00; esel = 4'b1010; en = 1'b1;
      observe(120);
      esel = 4'b0101;
      observe(60);
   endtask

   task automatic t_stereo();
      en = 1'b0; @(negedge clk);
      presc = 8'd1; num = 2'd3; ster = 2'b11; esel = 4'b1111; en = 1'b1;
      observe(100);
      esel = 4'b0000;
      observe(60);
      ster = 2'b01; esel = 4'b0110;
      observe(60);
   endtask

   task automatic t_count();
      en = 1'b0; @(negedge clk);
      presc = 8'd0; num = 2'd1; ster = 2'b00; esel = 4'b0010; en = 1'b1;
      observe(80);
      num = 2'd0;
      observe(40);
      num = 2'd2; presc = 8'd3;
      observe(80);
   endtask

   initial begin
      t_reset();
      t_period(0);
      t_period(1);
      t_period(4);
      t_mono();
      t_stereo();
      t_count();
      t_disable();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule